// File: doc/BRIEF.md
# Port Link Status Register Bank

This block gathers per-port link health for a network hub that has a configurable number of downstream ports. Each port carries four logical channels. Each channel reports timeout events, which are held as sticky flags. The block also passes through the live "stalled, waiting for acknowledge" levels and the live link error levels. Two further per-port sticky flags record incomplete-packet timeouts and slow-control errors. Two groups of per-port packet counters count received packets on two of the channels.

Software reaches every value over a small register bus: an 8-bit address, a read strobe and a write strobe. Read data comes back one cycle after the strobe. Sticky flags clear when they are read. A write to the first address of a counter group clears every counter in that group.

Any port that has a pending timeout flag on any channel blinks its link LED. The LED is off for a quarter of each blink period. A network reset clears the counters but leaves all sticky flags intact.

Top module: `portstat_bank`

## Requirements
- R1: A pulse on timeout input bit `c*NUM_PORTS+p` sets sticky bit p of the timeout register for channel c. That register is read at address 0x00+c, and bit p of the read data is port p.
- R2: A read of a timeout register, the packet-timeout register (0x09) or the slow-control error register (0x0A) returns the current contents and then clears them. Reads of any other register leave it unchanged.
- R3: If a set event and a clearing read reach the same flag in the same cycle, the read returns the old value and the flag is set afterwards.
- R4: Address 0x04+c returns the live wait-for-acknowledge levels of channel c, with bit p for port p. Address 0x08 returns the live link error level of each port. Neither value is stored.
- R5: A pulse on `pktTimeoutEvt[p]` sets bit p of the packet-timeout register, and a pulse on `scErrEvt[p]` sets bit p of the slow-control error register.
- R6: Each pulse on `pktRxA[p]` increments counter A of port p, read at 0x10+p. Each pulse on `pktRxB[p]` increments counter B of port p, read at 0x20+p. Counter values are zero-extended to 32 bits.
- R7: A write to 0x10 clears every A counter, and a write to 0x20 clears every B counter; the clear wins over an increment in the same cycle. Writes to any other address have no effect.
- R8: A counter that has reached its all-ones value stays there on further packets.
- R9: `netReset` clears all counters and leaves every sticky flag unchanged.
- R10: While a port has at least one timeout flag set, its `ledOn` output is low for BLINK_PERIOD/4 cycles of every BLINK_PERIOD cycles. Otherwise its `ledOn` output stays high.
- R11: `rdValid` pulses one cycle after `busRd`. A read of an unmapped address returns zero and raises `unknownAddr` for that one cycle. The unmapped addresses are 0x0B–0x0F, counter addresses whose port index is NUM_PORTS or more, and everything at 0x30 and above.
- R12: After the system reset, every flag and counter is zero and every `ledOn` output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | System reset, active high, synchronous |
| netReset | input | 1 | Network reset; clears counters only |
| timeoutEvt | input | 4*NUM_PORTS | Timeout pulses, channel-major |
| waitAck | input | 4*NUM_PORTS | Live stalled-for-acknowledge levels, channel-major |
| linkErr | input | NUM_PORTS | Live link error levels |
| pktTimeoutEvt | input | NUM_PORTS | Incomplete-packet timeout pulses |
| scErrEvt | input | NUM_PORTS | Slow-control error pulses |
| pktRxA | input | NUM_PORTS | Packet received on counted channel A |
| pktRxB | input | NUM_PORTS | Packet received on counted channel B |
| busAddr | input | 8 | Register address |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busRdata | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after busRd |
| unknownAddr | output | 1 | Unmapped address was read |
| ledOn | output | NUM_PORTS | Link LED drive per port |

## Verification
The bench runs a four-port configuration with 8-bit counters and an 8-cycle blink period. It pulses every single timeout bit alone on every channel and reads all four channel registers after each pulse. This shows that each event reaches the right register and bit, and that the read clears it. All 16 level patterns are applied to each wait-for-acknowledge channel and to the link error lines, which would expose swapped or stuck bits. Each port's counters receive a distinct number of packets, so that crossed counters show up. Other checks cover saturation, a clear that collides with an increment, a set that collides with a read, and the network reset. The LED is checked by counting lit cycles over one full period, for a port with a pending flag and for a port without one.

// File: rtl/portstat_pkg.sv
package portstat_pkg;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int NUM_CHAN = 4;

  localparam logic [3:0] NIB_FLAGS = 4'h0;
  localparam logic [3:0] NIB_CNTA  = 4'h1;
  localparam logic [3:0] NIB_CNTB  = 4'h2;

  localparam logic [3:0] LO_LERR  = 4'h8;
  localparam logic [3:0] LO_PKTTO = 4'h9;
  localparam logic [3:0] LO_SCERR = 4'hA;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_TO,
    SEL_WAIT,
    SEL_LERR,
    SEL_PKTTO,
    SEL_SCERR,
    SEL_CNTA,
    SEL_CNTB
  } rd_sel_e;

  typedef struct packed {
    logic                rdEn;
    rd_sel_e             sel;
    logic [1:0]          chan;
    logic [3:0]          port;
    logic [NUM_CHAN-1:0] clrTo;
    logic                clrPktTo;
    logic                clrScErr;
    logic                clrCntA;
    logic                clrCntB;
    logic                unknown;
  } ctl_strobe_t;

endpackage

// File: rtl/portstat_ctrl.sv
module portstat_ctrl
  import portstat_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output ctl_strobe_t       stb
);

  logic [3:0] hiNib;
  logic [3:0] loNib;
  logic       portInRange;

  assign hiNib       = busAddr[7:4];
  assign loNib       = busAddr[3:0];
  assign portInRange = (int'(loNib) < NUM_PORTS);

  always_comb begin
    stb       = '0;
    stb.sel   = SEL_NONE;
    stb.rdEn  = busRd;
    stb.chan  = loNib[1:0];
    stb.port  = loNib;
    unique case (hiNib)
      NIB_FLAGS: begin
        if (loNib < 4'h4) begin
          stb.sel = SEL_TO;
          stb.clrTo[loNib[1:0]] = busRd;
        end else if (loNib < 4'h8) begin
          stb.sel = SEL_WAIT;
        end else if (loNib == LO_LERR) begin
          stb.sel = SEL_LERR;
        end else if (loNib == LO_PKTTO) begin
          stb.sel = SEL_PKTTO;
          stb.clrPktTo = busRd;
        end else if (loNib == LO_SCERR) begin
          stb.sel = SEL_SCERR;
          stb.clrScErr = busRd;
        end
      end
      NIB_CNTA: begin
        if (portInRange) stb.sel = SEL_CNTA;
        stb.clrCntA = busWr && (loNib == 4'h0);
      end
      NIB_CNTB: begin
        if (portInRange) stb.sel = SEL_CNTB;
        stb.clrCntB = busWr && (loNib == 4'h0);
      end
      default: stb.sel = SEL_NONE;
    endcase
    stb.unknown = busRd && (stb.sel == SEL_NONE);
  end

endmodule

// File: rtl/portstat_datapath.sv
module portstat_datapath
  import portstat_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          netReset,
  input  ctl_strobe_t                   stb,
  input  logic [NUM_CHAN*NUM_PORTS-1:0] timeoutEvt,
  input  logic [NUM_CHAN*NUM_PORTS-1:0] waitAck,
  input  logic [NUM_PORTS-1:0]          linkErr,
  input  logic [NUM_PORTS-1:0]          pktTimeoutEvt,
  input  logic [NUM_PORTS-1:0]          scErrEvt,
  input  logic [NUM_PORTS-1:0]          pktRxA,
  input  logic [NUM_PORTS-1:0]          pktRxB,
  output logic [DATA_W-1:0]             rdData,
  output logic                          rdValid,
  output logic                          unknownAddr,
  output logic [NUM_CHAN*NUM_PORTS-1:0] toSticky,
  output logic [NUM_PORTS-1:0]          portHasTo
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [NUM_PORTS-1:0] toQ [NUM_CHAN];
  logic [NUM_PORTS-1:0] pktToQ;
  logic [NUM_PORTS-1:0] scErrQ;
  logic [CNT_W-1:0]     cntA [NUM_PORTS];
  logic [CNT_W-1:0]     cntB [NUM_PORTS];
  logic [DATA_W-1:0]    rdMux;

  // sticky timeout flags: the set term is OR-ed after the clear (R3)
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_to
    always_ff @(posedge clk) begin
      if (rst) toQ[c] <= '0;
      else     toQ[c] <= (toQ[c] & ~{NUM_PORTS{stb.clrTo[c]}})
                         | timeoutEvt[c*NUM_PORTS +: NUM_PORTS];
    end
    assign toSticky[c*NUM_PORTS +: NUM_PORTS] = toQ[c];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pktToQ <= '0;
      scErrQ <= '0;
    end else begin
      pktToQ <= (pktToQ & ~{NUM_PORTS{stb.clrPktTo}}) | pktTimeoutEvt;
      scErrQ <= (scErrQ & ~{NUM_PORTS{stb.clrScErr}}) | scErrEvt;
    end
  end

  // per-port saturating packet counters
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst || netReset || stb.clrCntA)   cntA[p] <= '0;
      else if (pktRxA[p] && cntA[p] != CNT_MAX) cntA[p] <= cntA[p] + 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst || netReset || stb.clrCntB)   cntB[p] <= '0;
      else if (pktRxB[p] && cntB[p] != CNT_MAX) cntB[p] <= cntB[p] + 1'b1;
    end
    assign portHasTo[p] = toQ[0][p] | toQ[1][p] | toQ[2][p] | toQ[3][p];
  end

  always_comb begin
    rdMux = '0;
    unique case (stb.sel)
      SEL_TO: begin
        for (int c = 0; c < NUM_CHAN; c++)
          if (stb.chan == 2'(c)) rdMux = DATA_W'(toQ[c]);
      end
      SEL_WAIT: begin
        for (int c = 0; c < NUM_CHAN; c++)
          if (stb.chan == 2'(c)) rdMux = DATA_W'(waitAck[c*NUM_PORTS +: NUM_PORTS]);
      end
      SEL_LERR:  rdMux = DATA_W'(linkErr);
      SEL_PKTTO: rdMux = DATA_W'(pktToQ);
      SEL_SCERR: rdMux = DATA_W'(scErrQ);
      SEL_CNTA: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (stb.port == 4'(p)) rdMux = DATA_W'(cntA[p]);
      end
      SEL_CNTB: begin
        for (int p = 0; p < NUM_PORTS; p++)
          if (stb.port == 4'(p)) rdMux = DATA_W'(cntB[p]);
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData      <= '0;
      rdValid     <= 1'b0;
      unknownAddr <= 1'b0;
    end else begin
      rdData      <= stb.rdEn ? rdMux : '0;
      rdValid     <= stb.rdEn;
      unknownAddr <= stb.unknown;
    end
  end

endmodule

// File: rtl/portstat_blink.sv
module portstat_blink #(
  parameter int NUM_PORTS    = 4,
  parameter int BLINK_PERIOD = 50_000_000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PORTS-1:0] portHasTo,
  output logic [NUM_PORTS-1:0] ledOn
);

  localparam int PH_W    = $clog2(BLINK_PERIOD);
  localparam int OFF_LEN = BLINK_PERIOD / 4;

  logic [PH_W-1:0] phase;
  logic            darkPhase;

  always_ff @(posedge clk) begin
    if (rst)                                phase <= '0;
    else if (phase == PH_W'(BLINK_PERIOD-1)) phase <= '0;
    else                                    phase <= phase + 1'b1;
  end

  assign darkPhase = (phase < PH_W'(OFF_LEN));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_led
    assign ledOn[p] = !(portHasTo[p] && darkPhase);
  end

endmodule

// File: rtl/portstat_bank.sv
module portstat_bank
  import portstat_pkg::*;
#(
  parameter int NUM_PORTS    = 4,
  parameter int CNT_W        = 32,
  parameter int BLINK_PERIOD = 50_000_000
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          netReset,
  input  logic [NUM_CHAN*NUM_PORTS-1:0] timeoutEvt,
  input  logic [NUM_CHAN*NUM_PORTS-1:0] waitAck,
  input  logic [NUM_PORTS-1:0]          linkErr,
  input  logic [NUM_PORTS-1:0]          pktTimeoutEvt,
  input  logic [NUM_PORTS-1:0]          scErrEvt,
  input  logic [NUM_PORTS-1:0]          pktRxA,
  input  logic [NUM_PORTS-1:0]          pktRxB,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busRd,
  input  logic                          busWr,
  output logic [DATA_W-1:0]             busRdata,
  output logic                          rdValid,
  output logic                          unknownAddr,
  output logic [NUM_PORTS-1:0]          ledOn
);

  ctl_strobe_t                   stb;
  logic [NUM_CHAN*NUM_PORTS-1:0] toSticky;
  logic [NUM_PORTS-1:0]          portHasTo;

  portstat_ctrl #(.NUM_PORTS(NUM_PORTS)) ctrl_i (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .stb     (stb)
  );

  portstat_datapath #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) dp_i (
    .clk           (clk),
    .rst           (rst),
    .netReset      (netReset),
    .stb           (stb),
    .timeoutEvt    (timeoutEvt),
    .waitAck       (waitAck),
    .linkErr       (linkErr),
    .pktTimeoutEvt (pktTimeoutEvt),
    .scErrEvt      (scErrEvt),
    .pktRxA        (pktRxA),
    .pktRxB        (pktRxB),
    .rdData        (busRdata),
    .rdValid       (rdValid),
    .unknownAddr   (unknownAddr),
    .toSticky      (toSticky),
    .portHasTo     (portHasTo)
  );

  portstat_blink #(.NUM_PORTS(NUM_PORTS), .BLINK_PERIOD(BLINK_PERIOD)) blink_i (
    .clk       (clk),
    .rst       (rst),
    .portHasTo (portHasTo),
    .ledOn     (ledOn)
  );

endmodule

// File: rtl/portstat_bank_chk.sv
module portstat_bank_chk #(
  parameter int NUM_PORTS = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   busRd,
  input logic                   rdValid,
  input logic                   unknownAddr,
  input logic [31:0]            busRdata,
  input logic [NUM_PORTS-1:0]   ledOn,
  input logic [NUM_PORTS-1:0]   portHasTo,
  input logic [4*NUM_PORTS-1:0] toSticky,
  input logic [4*NUM_PORTS-1:0] timeoutEvt
);

  p_rd_latency_r11: assert property (@(posedge clk) disable iff (rst)
    busRd |=> rdValid);

  p_valid_cause_r11: assert property (@(posedge clk) disable iff (rst)
    rdValid |-> $past(busRd));

  p_unknown_zero_r11: assert property (@(posedge clk) disable iff (rst)
    unknownAddr |-> (rdValid && busRdata == 32'd0));

  p_set_wins_r3: assert property (@(posedge clk) disable iff (rst)
    (timeoutEvt != '0) |=> ((toSticky & $past(timeoutEvt)) == $past(timeoutEvt)));

  p_hold_no_read_r9: assert property (@(posedge clk) disable iff (rst)
    !busRd |=> ((toSticky & $past(toSticky)) == $past(toSticky)));

  p_led_cause_r10: assert property (@(posedge clk) disable iff (rst)
    ((~ledOn) & (~portHasTo)) == '0);

endmodule

bind portstat_bank portstat_bank_chk #(.NUM_PORTS(NUM_PORTS)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .busRd       (busRd),
  .rdValid     (rdValid),
  .unknownAddr (unknownAddr),
  .busRdata    (busRdata),
  .ledOn       (ledOn),
  .portHasTo   (portHasTo),
  .toSticky    (toSticky),
  .timeoutEvt  (timeoutEvt)
);

// File: tb/portstat_bank_tb_top.sv
module portstat_bank_tb_top;

  localparam int NP  = 4;
  localparam int CW  = 8;
  localparam int BP  = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          netReset = 1'b0;
  logic [4*NP-1:0] timeoutEvt = '0;
  logic [4*NP-1:0] waitAck = '0;
  logic [NP-1:0] linkErr = '0;
  logic [NP-1:0] pktTimeoutEvt = '0;
  logic [NP-1:0] scErrEvt = '0;
  logic [NP-1:0] pktRxA = '0;
  logic [NP-1:0] pktRxB = '0;
  logic [7:0]    busAddr = '0;
  logic          busRd = 1'b0;
  logic          busWr = 1'b0;
  logic [31:0]   busRdata;
  logic          rdValid;
  logic          unknownAddr;
  logic [NP-1:0] ledOn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  portstat_bank #(.NUM_PORTS(NP), .CNT_W(CW), .BLINK_PERIOD(BP)) dut_i (
    .clk(clk), .rst(rst), .netReset(netReset), .timeoutEvt(timeoutEvt),
    .waitAck(waitAck), .linkErr(linkErr), .pktTimeoutEvt(pktTimeoutEvt),
    .scErrEvt(scErrEvt), .pktRxA(pktRxA), .pktRxB(pktRxB), .busAddr(busAddr),
    .busRd(busRd), .busWr(busWr), .busRdata(busRdata), .rdValid(rdValid),
    .unknownAddr(unknownAddr), .ledOn(ledOn)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  logic [31:0] rdD;
  logic        rdV, rdU;

  task automatic rd(input logic [7:0] a);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    rdD = busRdata; rdV = rdValid; rdU = unknownAddr;
  endtask

  task automatic wr(input logic [7:0] a);
    @(negedge clk);
    busAddr = a; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic countLed(input int p, output int lit);
    lit = 0;
    for (int k = 0; k < BP; k++) begin
      @(negedge clk);
      if (ledOn[p]) lit++;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int lit;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R12: reset state
    check("R12 led", 32'(ledOn), 32'hF);
    for (int a = 0; a < 11; a++) begin
      rd(8'(a));
      check("R12 flags zero", rdD, 0);
    end
    rd(8'h13); check("R12 cntA zero", rdD, 0);

    // R1, R2: single timeout bit sweep over channels and ports
    for (int c = 0; c < 4; c++) begin
      for (int p = 0; p < NP; p++) begin
        @(negedge clk); timeoutEvt[c*NP+p] = 1'b1;
        @(negedge clk); timeoutEvt = '0;
        for (int r = 0; r < 4; r++) begin
          rd(8'(r));
          check("R1 timeout bit", rdD, (r == c) ? (32'd1 << p) : 32'd0);
        end
        rd(8'(c));
        check("R2 cleared after read", rdD, 0);
      end
    end

    // R3: set and clearing read in the same cycle
    @(negedge clk); timeoutEvt[2*NP+1] = 1'b1; busAddr = 8'h02; busRd = 1'b1;
    @(negedge clk); timeoutEvt = '0; busRd = 1'b0;
    check("R3 old value returned", busRdata, 0);
    rd(8'h02); check("R3 flag survives", rdD, 32'h2);

    // R4: live levels, all patterns
    for (int c = 0; c < 4; c++) begin
      for (int pat = 0; pat < 16; pat++) begin
        waitAck = '0; waitAck[c*NP +: NP] = 4'(pat);
        rd(8'(4 + c));
        check("R4 wait ack", rdD, 32'(pat));
      end
    end
    waitAck = '0;
    for (int pat = 0; pat < 16; pat++) begin
      linkErr = 4'(pat);
      rd(8'h08); check("R4 link err", rdD, 32'(pat));
      rd(8'h08); check("R2 live not cleared", rdD, 32'(pat));
    end
    linkErr = '0;

    // R5: packet timeout and slow-control error stickies
    @(negedge clk); pktTimeoutEvt = 4'b1010; scErrEvt = 4'b0101;
    @(negedge clk); pktTimeoutEvt = '0; scErrEvt = '0;
    rd(8'h09); check("R5 pkt timeout", rdD, 32'hA);
    rd(8'h0A); check("R5 sc error", rdD, 32'h5);
    rd(8'h09); check("R2 pkt timeout clears", rdD, 0);
    rd(8'h0A); check("R2 sc error clears", rdD, 0);

    // R6: counters, distinct counts per port
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      for (int p = 0; p < NP; p++) begin
        pktRxA[p] = (k < p + 1);
        pktRxB[p] = (k < 2*p + 3);
      end
    end
    @(negedge clk); pktRxA = '0; pktRxB = '0;
    for (int p = 0; p < NP; p++) begin
      rd(8'(16 + p)); check("R6 cntA", rdD, 32'(p + 1));
      rd(8'(32 + p)); check("R6 cntB", rdD, 32'(2*p + 3));
    end

    // R7: clears
    wr(8'h11); rd(8'h11); check("R7 write off base ignored", rdD, 2);
    wr(8'h10);
    rd(8'h11); check("R7 cntA group cleared", rdD, 0);
    rd(8'h23); check("R7 cntB kept", rdD, 9);
    @(negedge clk); pktRxB[0] = 1'b1; busAddr = 8'h20; busWr = 1'b1;
    @(negedge clk); pktRxB = '0; busWr = 1'b0;
    rd(8'h20); check("R7 clear beats increment", rdD, 0);

    // R8: saturation
    @(negedge clk); pktRxA[2] = 1'b1;
    repeat (260) @(negedge clk);
    pktRxA = '0;
    rd(8'h12); check("R8 saturates", rdD, 255);

    // R9: network reset
    @(negedge clk); timeoutEvt[3*NP+3] = 1'b1; scErrEvt[1] = 1'b1;
    @(negedge clk); timeoutEvt = '0; scErrEvt = '0; netReset = 1'b1;
    @(negedge clk); netReset = 1'b0;
    rd(8'h12); check("R9 counter cleared", rdD, 0);
    rd(8'h03); check("R9 timeout kept", rdD, 32'h8);
    rd(8'h0A); check("R9 sc error kept", rdD, 32'h2);

    // R10: blink
    @(negedge clk); timeoutEvt[1*NP+1] = 1'b1;
    @(negedge clk); timeoutEvt = '0;
    countLed(1, lit); check("R10 blinking port lit cycles", 32'(lit), 32'(BP - BP/4));
    countLed(0, lit); check("R10 idle port steady", 32'(lit), 32'(BP));
    rd(8'h01);
    countLed(1, lit); check("R10 steady after clear", 32'(lit), 32'(BP));

    // R11: latency and unmapped
    rd(8'h08); check("R11 valid", 32'(rdV), 1); check("R11 known", 32'(rdU), 0);
    rd(8'h0B); check("R11 unknown 0B", 32'(rdU), 1); check("R11 zero data", rdD, 0);
    rd(8'h14); check("R11 unknown port idx", 32'(rdU), 1);
    rd(8'h30); check("R11 unknown 30", 32'(rdU), 1);
    rd(8'hFF); check("R11 unknown FF", 32'(rdU), 1);
    @(negedge clk); check("R11 unknown one cycle", 32'(unknownAddr), 0);
    check("R11 valid one cycle", 32'(rdValid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule